// File: doc/BRIEF.md
# Dual-Edge PDM Channel Demultiplexer

This block generates the bit clock for a set of pulse-density-modulated microphones and recovers up to four one-bit channels from two shared data lines. Two microphones share each line. One drives it while the clock is low and is captured on the rising edge. The other drives it while the clock is high and is captured on the falling edge. Each logical channel picks its source as a pair: a line index and an edge. It also has its own enable bit.

The clock runs only while at least one channel is enabled. Its half period is a programmable count of system cycles, so the divisor is always even. Each line passes through a synchronizer and is captured at both clock edges. The falling-edge capture is held until the following rising-edge capture, and both are presented together once per PDM period. The per-channel outputs are a sample bit and a one-cycle valid strobe that feed the decimation filters downstream.

Top module: `pdm_edge_demux`

## Requirements
- R1: While reset is high, `pdm_clk_o` is low and every `ch_valid_o` bit is low, whatever the enables are.
- R2: While running, `pdm_clk_o` stays high for `half_div` system cycles, then low for `half_div` cycles, so each rising edge comes 2*`half_div` cycles after the one before.
- R3: A channel whose `edge_sel` bit is 0 receives the value its line held during the low phase that ends at the latest rising edge.
- R4: A channel whose `edge_sel` bit is 1 receives the value its line held during the high phase just before that low phase.
- R5: For channel n, `line_sel` bit n equal to 0 selects `pdm_data_i[0]` and equal to 1 selects `pdm_data_i[1]`.
- R6: An enabled channel raises `ch_valid_o` for one cycle per PDM period, exactly two system cycles after `pdm_clk_o` is first seen high, with its `ch_bit_o` valid in that cycle.
- R7: A channel whose enable bit is 0 never raises `ch_valid_o`, while the other channels keep running.
- R8: When all enable bits are 0, `pdm_clk_o` is low from the next cycle on and no strobes appear. When any bit is set again, the clock restarts low and first rises `half_div` cycles after the enable took effect.
- R9: The first rising edge after a start produces no strobe, because no falling-edge sample has been taken yet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | DIV_W | Half period of the PDM clock in system cycles (0 acts as 1) |
| ch_enable | input | N_CH | Per-channel enable; all zero stops acquisition |
| edge_sel | input | N_CH | Per-channel edge: 0 rising, 1 falling |
| line_sel | input | N_CH*LW | Per-channel data-line index, LW bits per channel |
| pdm_data_i | input | N_LINES | Shared microphone data lines |
| pdm_clk_o | output | 1 | Generated PDM bit clock |
| ch_bit_o | output | N_CH | Latest sample bit per channel |
| ch_valid_o | output | N_CH | One-cycle strobe per channel when a new bit is presented |

## Verification
The assertions assume that the data lines change only away from the clock edges, that `half_div` is at least the synchronizer depth, and that `half_div`, `edge_sel` and `line_sel` change only while all enables are clear. The stimulus follows the same rules. It drives a fresh value on each line just after it sees a clock edge, keeps that value for the whole phase, and changes configuration only between stop and start. The sweep covers every edge and line combination and a range of enable masks, at three half-period values.

// File: rtl/pdm_demux_pkg.sv
package pdm_demux_pkg;

  // Both captures of one data line over one PDM period.
  typedef struct packed {
    logic rise_bit;  // value held during the low phase, captured at the rising edge
    logic fall_bit;  // value held during the high phase, captured at the falling edge
  } edge_pair_t;

  function automatic int sel_width(input int lines);
    return (lines > 1) ? $clog2(lines) : 1;
  endfunction

endpackage

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             pdm_clk,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit = (half_div == '0) ? DIV_W'(1) : half_div;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= '0;
      pdm_clk  <= 1'b0;
      rise_evt <= 1'b0;
      fall_evt <= 1'b0;
    end else begin
      rise_evt <= 1'b0;
      fall_evt <= 1'b0;
      if (cnt == limit - DIV_W'(1)) begin
        cnt      <= '0;
        pdm_clk  <= ~pdm_clk;
        rise_evt <= ~pdm_clk;
        fall_evt <= pdm_clk;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  // R8: stopping silences the clock and its edge events on the next cycle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!pdm_clk && !rise_evt && !fall_evt));

  // R2: the clock only moves together with an edge event
  p_clk_moves_with_event_r2: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !rise_evt && !fall_evt) |-> $stable(pdm_clk));

endmodule

// File: rtl/pdm_line_capture.sv
module pdm_line_capture
  import pdm_demux_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       rise_evt,
  input  logic       fall_evt,
  input  logic       pin,
  output edge_pair_t pair,
  output logic       pair_v
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;
  logic                   fall_hold;
  logic                   have_fall;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end

  assign line_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      have_fall <= 1'b0;
      fall_hold <= 1'b0;
      pair_v    <= 1'b0;
      pair      <= '0;
    end else begin
      pair_v <= 1'b0;
      if (fall_evt) begin
        fall_hold <= line_s;
        have_fall <= 1'b1;
      end
      if (rise_evt) begin
        pair_v        <= have_fall;
        pair.rise_bit <= line_s;
        pair.fall_bit <= fall_hold;
      end
    end
  end

  // R6: a pair is only ever presented after a rising edge event
  p_pair_after_rise_r6: assert property (@(posedge clk) disable iff (rst)
    pair_v |-> $past(rise_evt));

  // R9: a pair needs a falling capture since the clock started
  p_pair_needs_fall_r9: assert property (@(posedge clk) disable iff (rst)
    (rise_evt && !have_fall) |=> !pair_v);

endmodule

// File: rtl/pdm_chan_route.sv
module pdm_chan_route
  import pdm_demux_pkg::*;
#(
  parameter int N_CH    = 4,
  parameter int N_LINES = 2,
  parameter int LW      = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  edge_pair_t [N_LINES-1:0] pairs,
  input  logic [N_LINES-1:0]       pair_v,
  input  logic [N_CH-1:0]          ch_enable,
  input  logic [N_CH-1:0]          edge_sel,
  input  logic [N_CH*LW-1:0]       line_sel,
  output logic [N_CH-1:0]          ch_bit,
  output logic [N_CH-1:0]          ch_valid
);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [LW-1:0] idx;
    logic          src_v;
    logic          src_b;
    logic          v_q;
    logic          b_q;

    assign idx = line_sel[i*LW +: LW];

    always_comb begin
      src_v = 1'b0;
      src_b = 1'b0;
      for (int l = 0; l < N_LINES; l++) begin
        if (idx == LW'(l)) begin
          src_v = pair_v[l];
          src_b = edge_sel[i] ? pairs[l].fall_bit : pairs[l].rise_bit;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        b_q <= 1'b0;
      end else begin
        v_q <= src_v & ch_enable[i];
        if (src_v && ch_enable[i]) b_q <= src_b;
      end
    end

    assign ch_valid[i] = v_q;
    assign ch_bit[i]   = b_q;

    // R7: a strobe requires the channel enable in the previous cycle
    p_gate_r7: assert property (@(posedge clk) disable iff (rst)
      ch_valid[i] |-> $past(ch_enable[i]));

    // R5: a strobe comes from the pair of the selected line
    p_source_line_r5: assert property (@(posedge clk) disable iff (rst)
      ch_valid[i] |-> $past(src_v));
  end

endmodule

// File: rtl/pdm_edge_demux.sv
module pdm_edge_demux
  import pdm_demux_pkg::*;
#(
  parameter int N_CH        = 4,
  parameter int N_LINES     = 2,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LW         = sel_width(N_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DIV_W-1:0]     half_div,
  input  logic [N_CH-1:0]      ch_enable,
  input  logic [N_CH-1:0]      edge_sel,
  input  logic [N_CH*LW-1:0]   line_sel,
  input  logic [N_LINES-1:0]   pdm_data_i,
  output logic                 pdm_clk_o,
  output logic [N_CH-1:0]      ch_bit_o,
  output logic [N_CH-1:0]      ch_valid_o
);

  logic                     run;
  logic                     rise_evt;
  logic                     fall_evt;
  edge_pair_t [N_LINES-1:0] pairs;
  logic [N_LINES-1:0]       pair_v;

  assign run = |ch_enable;

  pdm_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .half_div (half_div),
    .pdm_clk  (pdm_clk_o),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    pdm_line_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt),
      .pin      (pdm_data_i[l]),
      .pair     (pairs[l]),
      .pair_v   (pair_v[l])
    );
  end

  pdm_chan_route #(.N_CH(N_CH), .N_LINES(N_LINES), .LW(LW)) u_route (
    .clk       (clk),
    .rst       (rst),
    .pairs     (pairs),
    .pair_v    (pair_v),
    .ch_enable (ch_enable),
    .edge_sel  (edge_sel),
    .line_sel  (line_sel),
    .ch_bit    (ch_bit_o),
    .ch_valid  (ch_valid_o)
  );

  // R1: reset keeps the clock low and every strobe low
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!pdm_clk_o && ch_valid_o == '0));

  // R8: two idle cycles leave no strobe in flight
  p_idle_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!run) && $past(!run, 2)) |-> (ch_valid_o == '0));

  // R6: one strobe per PDM period, so never two cycles in a row
  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
      ch_valid_o[i] |=> !ch_valid_o[i]);
  end

endmodule

// File: tb/tb_pdm_edge_demux.sv
module tb_pdm_edge_demux;

  localparam int N_CH = 4;
  localparam int N_LINES = 2;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic [DIV_W-1:0] half_div;
  logic [N_CH-1:0]  ch_enable;
  logic [N_CH-1:0]  edge_sel;
  logic [N_CH-1:0]  line_sel;
  logic [N_LINES-1:0] pdm_data_i;
  logic             pdm_clk_o;
  logic [N_CH-1:0]  ch_bit_o;
  logic [N_CH-1:0]  ch_valid_o;

  pdm_edge_demux dut (
    .clk(clk), .rst(rst), .half_div(half_div), .ch_enable(ch_enable),
    .edge_sel(edge_sel), .line_sel(line_sel), .pdm_data_i(pdm_data_i),
    .pdm_clk_o(pdm_clk_o), .ch_bit_o(ch_bit_o), .ch_valid_o(ch_valid_o)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  logic [31:0]        rng = 32'h1234_5678;
  logic [N_LINES-1:0] cur_data;
  logic [N_LINES-1:0] high_val;
  logic [N_LINES-1:0] exp_r, exp_f;
  bit   prev_p, have_fall, first_rise, pend_ok;
  int   pend, cyc_run, cyc_rise;

  function automatic logic [N_LINES-1:0] next_bits();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng[N_LINES-1:0];
  endfunction

  task automatic fail_msg(input string req, input int act, input int exp);
    fails++;
    $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
  endtask

  task automatic clear_model();
    prev_p = 0; have_fall = 0; first_rise = 1; pend = 0; pend_ok = 0;
    cyc_run = 0; cyc_rise = 0;
  endtask

  task automatic step();
    bit expect_now;
    @(negedge clk);
    if (ch_enable == '0) begin
      // R8: stopped state
      checks++;
      if (pdm_clk_o !== 1'b0) fail_msg("R8 clock low when stopped", pdm_clk_o, 0);
      checks++;
      if (ch_valid_o !== '0) fail_msg("R8 no strobe when stopped", ch_valid_o, 0);
      clear_model();
    end else begin
      cyc_run++;
      cyc_rise++;
      expect_now = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) expect_now = 1;
      end
      for (int i = 0; i < N_CH; i++) begin
        bit ev;
        logic eb;
        ev = expect_now && pend_ok && ch_enable[i];
        checks++;
        if (ch_valid_o[i] !== ev) begin
          if (!ch_enable[i])               fail_msg("R7 disabled channel strobe", ch_valid_o[i], ev);
          else if (expect_now && !pend_ok) fail_msg("R9 first rise strobe", ch_valid_o[i], ev);
          else                             fail_msg("R6 strobe timing", ch_valid_o[i], ev);
        end else if (ev) begin
          eb = edge_sel[i] ? exp_f[line_sel[i]] : exp_r[line_sel[i]];
          checks++;
          if (ch_bit_o[i] !== eb) begin
            if (edge_sel[i]) fail_msg("R4 falling sample (line R5)", ch_bit_o[i], eb);
            else             fail_msg("R3 rising sample (line R5)", ch_bit_o[i], eb);
          end
        end
      end
      if (pdm_clk_o && !prev_p) begin
        checks++;
        if (first_rise) begin
          if (cyc_run != int'(half_div)) fail_msg("R8 first rise delay", cyc_run, half_div);
        end else begin
          if (cyc_rise != 2 * int'(half_div)) fail_msg("R2 clock period", cyc_rise, 2 * half_div);
        end
        first_rise = 0;
        cyc_rise = 0;
        exp_r = cur_data;
        exp_f = high_val;
        pend = 2;
        pend_ok = have_fall;
        cur_data = next_bits();
      end else if (!pdm_clk_o && prev_p) begin
        high_val = cur_data;
        have_fall = 1;
        cur_data = next_bits();
      end
      prev_p = pdm_clk_o;
    end
    pdm_data_i = cur_data;
  endtask

  task automatic run_cfg(input int h, input logic [7:0] cfg);
    half_div = DIV_W'(h);
    edge_sel = cfg[3:0];
    line_sel = cfg[7:4];
    step();
    ch_enable = (cfg % 3 == 0) ? {cfg[1:0], ~cfg[1:0]} : 4'hF;
    repeat (12 * h + 3) step();
    ch_enable = '0;
    repeat (4) step();
  endtask

  initial begin
    rst = 1'b1;
    ch_enable = 4'hF;
    edge_sel = '0;
    line_sel = '0;
    half_div = DIV_W'(2);
    cur_data = '0;
    high_val = '0;
    exp_r = '0;
    exp_f = '0;
    pdm_data_i = '0;
    clear_model();
    repeat (4) begin
      @(negedge clk);
      // R1: reset dominates the enables
      checks++;
      if (pdm_clk_o !== 1'b0) fail_msg("R1 clock in reset", pdm_clk_o, 0);
      checks++;
      if (ch_valid_o !== '0) fail_msg("R1 strobe in reset", ch_valid_o, 0);
    end
    ch_enable = '0;
    @(negedge clk);
    rst = 1'b0;
    repeat (2) step();
    foreach (hv[k]) begin
      for (int c = 0; c < 256; c++) run_cfg(hv[k], 8'(c));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int hv[3] = '{2, 3, 5};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule